// File: doc/BRIEF.md
# DRAM Bank Page-Policy Command Proposer

This block is the per-bank control machine of a DRAM controller. It tracks whether its bank is closed (precharged) or holds an open row, and it looks at the request at the head of the bank's queue. From that it proposes the single next command the bank wants on the command bus: activate, precharge, or a column read or write, with or without auto-precharge. A central command multiplexer collects the proposals of all bank machines on a rank and issues one. The issued command is then broadcast back, and each bank machine updates its own state.

The row-buffer management scheme is fixed at build time by a parameter. Four schemes are offered. One keeps rows open. One always closes after a column access. Two adaptive variants choose between a plain and an auto-precharge column command from two hints supplied by the request queue: whether this bank has further requests, and whether any of them hits the open row. An external timing checker returns the earliest legal time for the proposed command. The block attaches that time to the proposal and flags the proposal as issuable only in the cycle where that time equals the current time.

Top module: `bank_page_ctl`

## Requirements
- R1: When `sleeping` is high or `req_valid` is low, the proposal is NOP (code 0) with `prop_time` all ones and `prop_ready` low.
- R2: With the bank closed and a valid request, the proposal is ACT (code 1) when `blocked` is low and NOP when `blocked` is high.
- R3: Open-row scheme (POLICY 0): on a row hit the proposal is RD (3) for `req_op` 0 and WR (4) for `req_op` 1; on a row miss it is PRE (2) when not blocked, else NOP.
- R4: Close-after-access scheme (POLICY 1): with a row open the proposal is RDA (5) or WRA (6) by request type, whatever the requested row.
- R5: Adaptive-open scheme (POLICY 2): on a row hit an auto-precharge command is proposed only when `more_req` is high and `more_hit` is low; otherwise RD/WR. A row miss behaves as in R3.
- R6: Adaptive-close scheme (POLICY 3): on a row hit RD/WR is proposed when `more_hit` is high, otherwise RDA/WRA; a row miss while not blocked proposes NOP and sets `err_flag` at the next edge.
- R7: For a non-NOP proposal `prop_time` equals `chk_time`; `prop_ready` is high exactly when the proposal is not NOP and `chk_time` equals `now_time`.
- R8: An issued ACT for this bank opens it and latches `req_row` as `open_row`; an issued PRE, RDA or WRA for this bank, or PREA (7) for any bank, closes it; RD, WR and REFA (8) leave the state unchanged.
- R9: A bank-level command issued with `iss_bank` different from this bank's index leaves `bank_open` and `open_row` unchanged.
- R10: `bank_group` equals the bank index divided by the number of banks per group.
- R11: A `req_op` of 2 or 3 reaching a column decision yields NOP and sets `err_flag`, which stays high until reset.
- R12: After reset the bank is closed and `err_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Head request present |
| req_op | input | 2 | Head request type: 0 read, 1 write, 2 and 3 illegal |
| req_row | input | ROW_W | Row targeted by the head request |
| more_req | input | 1 | Queue holds further requests for this bank |
| more_hit | input | 1 | Queue holds further requests hitting the open row |
| blocked | input | 1 | Suppresses ACT and PRE proposals |
| sleeping | input | 1 | Bank machine parked; propose nothing |
| now_time | input | TIME_W | Current time in controller cycles |
| chk_time | input | TIME_W | Earliest legal time for the proposed command |
| iss_valid | input | 1 | A command was issued this cycle |
| iss_cmd | input | 4 | Issued command code |
| iss_bank | input | BANK_W | Bank addressed by the issued command |
| prop_cmd | output | 4 | Proposed command code |
| prop_time | output | TIME_W | Time attached to the proposal |
| prop_ready | output | 1 | Proposal issuable in this cycle |
| bank_group | output | GRP_W | Bank group of this bank |
| bank_open | output | 1 | A row is open |
| open_row | output | ROW_W | The open row |
| err_flag | output | 1 | Sticky error indication |

## Verification
The bound checker watches, every cycle, that an idle or sleeping bank proposes nothing, that ACT is only proposed for a closed bank and never while blocked, that ready implies a matching time, and that issued commands open, close or leave the bank as R8 and R9 demand, with the error flag never dropping outside reset. The choice between plain and auto-precharge column commands under each of the four schemes, and the exact code proposed for each mix of row hit, request type and queue hints, are shown only by the bench, which runs four instances side by side against one reference model under random and directed traffic.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic [3:0] {
        C_NOP  = 4'd0,
        C_ACT  = 4'd1,
        C_PRE  = 4'd2,
        C_RD   = 4'd3,
        C_WR   = 4'd4,
        C_RDA  = 4'd5,
        C_WRA  = 4'd6,
        C_PREA = 4'd7,
        C_REFA = 4'd8
    } bcmd_e;

    localparam int POL_OPEN         = 0;
    localparam int POL_CLOSED       = 1;
    localparam int POL_OPEN_ADAPT   = 2;
    localparam int POL_CLOSED_ADAPT = 3;

    typedef struct packed {
        logic more_req;
        logic more_hit;
        logic blocked;
        logic sleeping;
    } qhint_t;

    function automatic logic is_rank_cmd(bcmd_e c);
        return (c == C_PREA) || (c == C_REFA);
    endfunction

    function automatic logic closes_row(bcmd_e c);
        return (c == C_PRE) || (c == C_RDA) || (c == C_WRA) || (c == C_PREA);
    endfunction

    function automatic logic op_legal(logic [1:0] op);
        return op[1] == 1'b0;
    endfunction

    // decides the auto-precharge choice for a row hit
    function automatic logic want_auto(int pol, qhint_t h);
        case (pol)
            POL_CLOSED:       return 1'b1;
            POL_OPEN_ADAPT:   return h.more_req && !h.more_hit;
            POL_CLOSED_ADAPT: return !h.more_hit;
            default:          return 1'b0;
        endcase
    endfunction

    function automatic bcmd_e col_cmd(logic is_wr, logic auto_pre);
        if (is_wr) return auto_pre ? C_WRA : C_WR;
        return auto_pre ? C_RDA : C_RD;
    endfunction

endpackage

// File: rtl/bpc_state_trk.sv
module bpc_state_trk
    import bpc_pkg::*;
#(
    parameter int ROW_W    = 14,
    parameter int BANK_W   = 3,
    parameter int BANK_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  bcmd_e             iss_cmd,
    input  logic [BANK_W-1:0] iss_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic              err_now,
    output logic              is_open,
    output logic [ROW_W-1:0]  row_q,
    output logic              err_q
);
    localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_IDX);

    logic applies;
    assign applies = iss_valid && (is_rank_cmd(iss_cmd) || (iss_bank == MY_BANK));

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            row_q   <= '0;
        end else if (applies) begin
            if (iss_cmd == C_ACT) begin
                is_open <= 1'b1;
                row_q   <= act_row;
            end else if (closes_row(iss_cmd)) begin
                is_open <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_q | err_now;
    end

endmodule

// File: rtl/bpc_policy_pick.sv
module bpc_policy_pick
    import bpc_pkg::*;
#(
    parameter int POLICY = POL_OPEN,
    parameter int ROW_W  = 14
) (
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [ROW_W-1:0] req_row,
    input  qhint_t           hint,
    input  logic             is_open,
    input  logic [ROW_W-1:0] row_q,
    output bcmd_e            cmd,
    output logic             err_now
);
    logic active, hit, col_path, miss_path, miss_err, bad_op;

    assign active    = req_valid && !hint.sleeping;
    assign hit       = (req_row == row_q);
    // column decision: row hit, or the close-after-access scheme which ignores the row
    assign col_path  = active && is_open && (hit || (POLICY == POL_CLOSED));
    assign miss_path = active && is_open && !col_path;
    assign bad_op    = col_path && !op_legal(req_op);

    generate
        if (POLICY == POL_CLOSED_ADAPT) begin : g_miss_err
            assign miss_err = miss_path && !hint.blocked;
        end else begin : g_miss_ok
            assign miss_err = 1'b0;
        end
    endgenerate

    assign err_now = bad_op || miss_err;

    always_comb begin
        cmd = C_NOP;
        if (active && !is_open) begin
            if (!hint.blocked) cmd = C_ACT;
        end else if (col_path) begin
            if (!bad_op) cmd = col_cmd(req_op[0], want_auto(POLICY, hint));
        end else if (miss_path) begin
            if (!hint.blocked && (POLICY != POL_CLOSED_ADAPT)) cmd = C_PRE;
        end
    end

endmodule

// File: rtl/bpc_time_tag.sv
module bpc_time_tag
    import bpc_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  bcmd_e             cmd,
    input  logic [TIME_W-1:0] chk_time,
    input  logic [TIME_W-1:0] now_time,
    output logic [TIME_W-1:0] tag_time,
    output logic              ready
);
    logic none;
    assign none     = (cmd == C_NOP);
    assign tag_time = none ? '1 : chk_time;
    assign ready    = !none && (tag_time == now_time);
endmodule

// File: rtl/bank_page_ctl.sv
module bank_page_ctl
    import bpc_pkg::*;
#(
    parameter int POLICY          = POL_OPEN,
    parameter int ROW_W           = 14,
    parameter int TIME_W          = 16,
    parameter int NUM_BANKS       = 8,
    parameter int BANKS_PER_GROUP = 4,
    parameter int BANK_IDX        = 5,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int NUM_GRPS = NUM_BANKS / BANKS_PER_GROUP,
    localparam int GRP_W    = (NUM_GRPS > 1) ? $clog2(NUM_GRPS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              more_req,
    input  logic              more_hit,
    input  logic              blocked,
    input  logic              sleeping,
    input  logic [TIME_W-1:0] now_time,
    input  logic [TIME_W-1:0] chk_time,
    input  logic              iss_valid,
    input  logic [3:0]        iss_cmd,
    input  logic [BANK_W-1:0] iss_bank,
    output logic [3:0]        prop_cmd,
    output logic [TIME_W-1:0] prop_time,
    output logic              prop_ready,
    output logic [GRP_W-1:0]  bank_group,
    output logic              bank_open,
    output logic [ROW_W-1:0]  open_row,
    output logic              err_flag
);
    localparam int GROUP_IDX = BANK_IDX / BANKS_PER_GROUP;

    qhint_t hint;
    bcmd_e  pick_cmd;
    logic   err_now;

    assign hint = '{more_req: more_req, more_hit: more_hit,
                    blocked: blocked, sleeping: sleeping};

    bpc_state_trk #(.ROW_W(ROW_W), .BANK_W(BANK_W), .BANK_IDX(BANK_IDX)) u_state (
        .clk       (clk),
        .rst       (rst),
        .iss_valid (iss_valid),
        .iss_cmd   (bcmd_e'(iss_cmd)),
        .iss_bank  (iss_bank),
        .act_row   (req_row),
        .err_now   (err_now),
        .is_open   (bank_open),
        .row_q     (open_row),
        .err_q     (err_flag)
    );

    bpc_policy_pick #(.POLICY(POLICY), .ROW_W(ROW_W)) u_pick (
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_row   (req_row),
        .hint      (hint),
        .is_open   (bank_open),
        .row_q     (open_row),
        .cmd       (pick_cmd),
        .err_now   (err_now)
    );

    bpc_time_tag #(.TIME_W(TIME_W)) u_time (
        .cmd      (pick_cmd),
        .chk_time (chk_time),
        .now_time (now_time),
        .tag_time (prop_time),
        .ready    (prop_ready)
    );

    assign prop_cmd   = pick_cmd;
    assign bank_group = GRP_W'(GROUP_IDX);

endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
    parameter int ROW_W    = 14,
    parameter int TIME_W   = 16,
    parameter int BANK_W   = 3,
    parameter int BANK_IDX = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ROW_W-1:0]  req_row,
    input logic              blocked,
    input logic              sleeping,
    input logic [TIME_W-1:0] now_time,
    input logic              iss_valid,
    input logic [3:0]        iss_cmd,
    input logic [BANK_W-1:0] iss_bank,
    input logic [3:0]        prop_cmd,
    input logic [TIME_W-1:0] prop_time,
    input logic              prop_ready,
    input logic              bank_open,
    input logic [ROW_W-1:0]  open_row,
    input logic              err_flag
);
    logic mine, rank_wide;
    assign rank_wide = (iss_cmd == 4'd7) || (iss_cmd == 4'd8);
    assign mine      = iss_valid && (rank_wide || (iss_bank == BANK_W'(BANK_IDX)));

    a_r1_idle_nop: assert property (@(posedge clk) disable iff (rst)
        (sleeping || !req_valid) |-> (prop_cmd == 4'd0 && (&prop_time) && !prop_ready));

    a_r2_act_closed: assert property (@(posedge clk) disable iff (rst)
        (prop_cmd == 4'd1) |-> (!bank_open && !blocked));

    a_r2_blocked_quiet: assert property (@(posedge clk) disable iff (rst)
        blocked |-> (prop_cmd != 4'd1 && prop_cmd != 4'd2));

    a_r7_ready_time: assert property (@(posedge clk) disable iff (rst)
        prop_ready |-> (prop_time == now_time && prop_cmd != 4'd0));

    a_r8_act_opens: assert property (@(posedge clk) disable iff (rst)
        (mine && iss_cmd == 4'd1) |=> (bank_open && open_row == $past(req_row)));

    a_r8_close: assert property (@(posedge clk) disable iff (rst)
        (mine && (iss_cmd == 4'd2 || iss_cmd == 4'd5 || iss_cmd == 4'd6 || iss_cmd == 4'd7))
        |=> !bank_open);

    a_r9_other_bank: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !rank_wide && iss_bank != BANK_W'(BANK_IDX))
        |=> ($stable(bank_open) && $stable(open_row)));

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

endmodule

bind bank_page_ctl bpc_checker #(
    .ROW_W(ROW_W), .TIME_W(TIME_W), .BANK_W(BANK_W), .BANK_IDX(BANK_IDX)
) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_row(req_row),
    .blocked(blocked), .sleeping(sleeping), .now_time(now_time),
    .iss_valid(iss_valid), .iss_cmd(iss_cmd), .iss_bank(iss_bank),
    .prop_cmd(prop_cmd), .prop_time(prop_time), .prop_ready(prop_ready),
    .bank_open(bank_open), .open_row(open_row), .err_flag(err_flag)
);

// File: tb/bank_page_ctl_tb_top.sv
`timescale 1ns/1ps
module bank_page_ctl_tb_top;
    localparam int ROW_W = 14, TIME_W = 16, BANK_W = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic              more_req = 1'b0, more_hit = 1'b0, blocked = 1'b0, sleeping = 1'b0;
    logic [TIME_W-1:0] now_time = '0, chk_time = '0;
    logic              iss_valid = 1'b0;
    logic [3:0]        iss_cmd = '0;
    logic [BANK_W-1:0] iss_bank = '0;

    logic [3:0]        pc [4];
    logic [TIME_W-1:0] pt [4];
    logic              prdy [4];
    logic [0:0]        pg [4];
    logic              popen [4];
    logic [ROW_W-1:0]  prow [4];
    logic              perr [4];

    int n_checks = 0, n_fail = 0;

    // reference state
    logic             ref_open = 1'b0;
    logic [ROW_W-1:0] ref_row = '0;
    logic             ref_err [4];
    logic             eerr [4];

    bank_page_ctl #(.POLICY(0)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_row(req_row),
        .more_req(more_req), .more_hit(more_hit), .blocked(blocked), .sleeping(sleeping),
        .now_time(now_time), .chk_time(chk_time), .iss_valid(iss_valid), .iss_cmd(iss_cmd),
        .iss_bank(iss_bank), .prop_cmd(pc[0]), .prop_time(pt[0]), .prop_ready(prdy[0]),
        .bank_group(pg[0]), .bank_open(popen[0]), .open_row(prow[0]), .err_flag(perr[0]));
    bank_page_ctl #(.POLICY(1)) dut_cl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_row(req_row),
        .more_req(more_req), .more_hit(more_hit), .blocked(blocked), .sleeping(sleeping),
        .now_time(now_time), .chk_time(chk_time), .iss_valid(iss_valid), .iss_cmd(iss_cmd),
        .iss_bank(iss_bank), .prop_cmd(pc[1]), .prop_time(pt[1]), .prop_ready(prdy[1]),
        .bank_group(pg[1]), .bank_open(popen[1]), .open_row(prow[1]), .err_flag(perr[1]));
    bank_page_ctl #(.POLICY(2)) dut_oa (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_row(req_row),
        .more_req(more_req), .more_hit(more_hit), .blocked(blocked), .sleeping(sleeping),
        .now_time(now_time), .chk_time(chk_time), .iss_valid(iss_valid), .iss_cmd(iss_cmd),
        .iss_bank(iss_bank), .prop_cmd(pc[2]), .prop_time(pt[2]), .prop_ready(prdy[2]),
        .bank_group(pg[2]), .bank_open(popen[2]), .open_row(prow[2]), .err_flag(perr[2]));
    bank_page_ctl #(.POLICY(3)) dut_ca (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_row(req_row),
        .more_req(more_req), .more_hit(more_hit), .blocked(blocked), .sleeping(sleeping),
        .now_time(now_time), .chk_time(chk_time), .iss_valid(iss_valid), .iss_cmd(iss_cmd),
        .iss_bank(iss_bank), .prop_cmd(pc[3]), .prop_time(pt[3]), .prop_ready(prdy[3]),
        .bank_group(pg[3]), .bank_open(popen[3]), .open_row(prow[3]), .err_flag(perr[3]));

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected proposal for scheme p, derived from the requirements
    function automatic logic [3:0] exp_cmd(int p, output logic e, output string tag);
        logic hit, auto_pre;
        e = 1'b0;
        if (sleeping || !req_valid) begin tag = "R1"; return 4'd0; end
        if (!ref_open) begin tag = "R2"; return blocked ? 4'd0 : 4'd1; end
        hit = (req_row == ref_row);
        tag = (p == 0) ? "R3" : (p == 1) ? "R4" : (p == 2) ? "R5" : "R6";
        if (!hit && p != 1) begin
            if (p == 3) begin e = !blocked; return 4'd0; end
            return blocked ? 4'd0 : 4'd2;
        end
        if (req_op > 2'd1) begin e = 1'b1; tag = "R11"; return 4'd0; end
        case (p)
            0:       auto_pre = 1'b0;
            1:       auto_pre = 1'b1;
            2:       auto_pre = more_req && !more_hit;
            default: auto_pre = !more_hit;
        endcase
        if (req_op[0]) return auto_pre ? 4'd6 : 4'd4;
        return auto_pre ? 4'd5 : 4'd3;
    endfunction

    task automatic cyc_end();
        #1;
        for (int p = 0; p < 4; p++) begin
            logic [3:0] ec;
            logic [TIME_W-1:0] et;
            logic er;
            string tag;
            ec = exp_cmd(p, eerr[p], tag);
            check(pc[p] == ec, tag, 32'(pc[p]), 32'(ec));
            et = (ec == 4'd0) ? '1 : chk_time;
            check(pt[p] == et, "R7", 32'(pt[p]), 32'(et));
            er = (ec != 4'd0) && (chk_time == now_time);
            check(prdy[p] == er, "R7", 32'(prdy[p]), 32'(er));
            check(perr[p] == ref_err[p], "R11", 32'(perr[p]), 32'(ref_err[p]));
            check(popen[p] == ref_open, "R8", 32'(popen[p]), 32'(ref_open));
            if (ref_open) check(prow[p] == ref_row, "R8", 32'(prow[p]), 32'(ref_row));
        end
        @(posedge clk);
        if (rst) begin
            ref_open = 1'b0;
            for (int p = 0; p < 4; p++) ref_err[p] = 1'b0;
        end else begin
            for (int p = 0; p < 4; p++) ref_err[p] = ref_err[p] | eerr[p];
            if (iss_valid && (iss_cmd == 4'd7 || iss_cmd == 4'd8 || iss_bank == 3'd5)) begin
                if (iss_cmd == 4'd1) begin ref_open = 1'b1; ref_row = req_row; end
                else if (iss_cmd == 4'd2 || iss_cmd == 4'd5 || iss_cmd == 4'd6 || iss_cmd == 4'd7)
                    ref_open = 1'b0;
            end
        end
    endtask

    task automatic quiet();
        @(negedge clk);
        now_time = now_time + 1'b1;
        rst = 1'b0; req_valid = 1'b0; iss_valid = 1'b0; sleeping = 1'b0; blocked = 1'b0;
        chk_time = now_time;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1: watchdog expired, actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int p = 0; p < 4; p++) begin ref_err[p] = 1'b0; eerr[p] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R12 reset state, R10 group index
        for (int p = 0; p < 4; p++) begin
            check(popen[p] == 1'b0, "R12", 32'(popen[p]), 0);
            check(perr[p] == 1'b0, "R12", 32'(perr[p]), 0);
            check(pg[p] == 1'b1, "R10", 32'(pg[p]), 1);
        end

        // R9: ACT addressed to bank 2 must not open bank 5
        quiet(); req_valid = 1'b1; req_row = 14'd9; iss_valid = 1'b1; iss_cmd = 4'd1; iss_bank = 3'd2;
        cyc_end();
        quiet(); #1;
        for (int p = 0; p < 4; p++) check(popen[p] == 1'b0, "R9", 32'(popen[p]), 0);
        cyc_end();

        // open row 9, then illegal op on a hit: R11 sticky error
        quiet(); req_valid = 1'b1; req_row = 14'd9; iss_valid = 1'b1; iss_cmd = 4'd1; iss_bank = 3'd5;
        cyc_end();
        quiet(); req_valid = 1'b1; req_row = 14'd9; req_op = 2'd2;
        cyc_end();
        quiet(); req_valid = 1'b1; req_row = 14'd9; req_op = 2'd0;
        cyc_end();
        quiet(); #1;
        for (int p = 0; p < 4; p++) check(perr[p] == 1'b1, "R11", 32'(perr[p]), 1);
        cyc_end();
        quiet(); rst = 1'b1;
        cyc_end();

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            now_time  = now_time + 1'b1;
            rst       = (c % 250) == 249;
            req_valid = ($urandom % 8) != 0;
            req_op    = (($urandom % 60) == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
            req_row   = ROW_W'($urandom % 4);
            more_req  = $urandom % 2;
            more_hit  = $urandom % 2;
            blocked   = ($urandom % 4) == 0;
            sleeping  = ($urandom % 10) == 0;
            chk_time  = now_time + TIME_W'($urandom % 3);
            iss_valid = ($urandom % 3) == 0;
            iss_cmd   = 4'($urandom % 9);
            iss_bank  = (($urandom % 3) == 0) ? 3'd2 : 3'd5;
            cyc_end();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule